// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block drives a parallel RGB panel. It produces horizontal sync, vertical sync, data-enable and a pixel clock, and it exports the current pixel and line position so that a pixel pipeline can fetch and present data in step with the panel. Software sets the sync widths, porches, active sizes and clock divider as "count minus one" values. One bit per output picks that output's polarity, and a single enable starts or stops scanning.

Each line runs through four segments in this order: sync, back porch, active, front porch. Each frame runs through the same four segments in lines. One pixel position lasts a whole number of source clock cycles, set by the divider. At the start of every frame the block takes a new copy of the whole timing setup, including the divider and the enable, so changes made during a frame never break the frame in progress. A frame-start interrupt flag can be enabled, and it is cleared by a clear strobe.

Top module: `rgb_panel_timing`

## Requirements
- R1: While reset is held and after it is released with the enable low, hsync and vsync are high, de and pclk are low (with all inversion bits clear), h_pos and v_pos are 0 and irq is 0.
- R2: In a line, hsync is driven low (before inversion) for the first hsw_m1+1 pixel positions, starting at h_pos 0. A line lasts (hsw_m1+1)+(hbp_m1+1)+(hact_m1+1)+(hfp_m1+1) positions.
- R3: In a frame, vsync is driven low (before inversion) for whole lines 0 to vsw_m1. A frame lasts (vsw_m1+1)+(vbp_m1+1)+(vact_m1+1)+(vfp_m1+1) lines.
- R4: de is high (before inversion) only when h_pos lies in [hsw+hbp, hsw+hbp+hact) and v_pos lies in [vsw+vbp, vsw+vbp+vact), where each term is its field plus one.
- R5: inv_hsync, inv_vsync, inv_de and inv_pclk each invert only their own output. They act immediately, both while scanning and while idle.
- R6: The divide ratio is div_m1+1, limited to 255, so div_m1 of 255 gives 255. Each pixel position lasts that many source cycles. For ratios of 2 or more, the raw pclk is low for the first floor(ratio/2) cycles of the position and high for the rest.
- R7: When the ratio is 1, the divider is bypassed and the raw pclk is the source clock itself.
- R8: h_pos counts pixel positions from 0 and wraps to 0 after the last position of the line. v_pos then advances and wraps to 0 after the last line of the frame.
- R9: irq is set in the cycle a frame starts if irq_en is high, and stays set until a cycle with irq_clr high. If both happen in the same cycle, the set wins.
- R10: The divider, the enable and all timing fields are sampled only when a frame starts. Changes to them during a frame have no effect on the outputs until the next frame.
- R11: When the enable is low at the end of a frame, scanning stops. Outputs go to their idle levels (R1 levels, after inversion) and h_pos and v_pos return to 0.
- R12: While idle, raising the enable starts a frame in the next cycle at h_pos 0, v_pos 0, and this counts as a frame start for R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Scan enable, sampled at frame start |
| hsw_m1 | input | PW | Hsync width in pixels, minus one |
| hbp_m1 | input | PW | Horizontal back porch, minus one |
| hfp_m1 | input | PW | Horizontal front porch, minus one |
| hact_m1 | input | AW | Active pixels per line, minus one |
| vsw_m1 | input | PW | Vsync width in lines, minus one |
| vbp_m1 | input | PW | Vertical back porch, minus one |
| vfp_m1 | input | PW | Vertical front porch, minus one |
| vact_m1 | input | AW | Active lines per frame, minus one |
| inv_hsync | input | 1 | Invert hsync |
| inv_vsync | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert de |
| inv_pclk | input | 1 | Invert pclk |
| div_m1 | input | DW | Pixel clock divide ratio, minus one |
| irq_en | input | 1 | Allow the frame-start flag to set |
| irq_clr | input | 1 | Clear strobe for the frame-start flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk | output | 1 | Pixel clock |
| h_pos | output | AW+2 | Current pixel position in the line |
| v_pos | output | AW+2 | Current line in the frame |
| irq | output | 1 | Frame-start flag |

## Verification
The bench goes after the smallest legal timing, where every field is zero. A design that dropped the plus-one would produce segments of zero length and a line three positions short. It drives a divider field of 255, where a design without the limit would stretch each position to 256 cycles. It also drives a ratio of 1, where a divider that is not bypassed would stall or give a flat clock. Mid-frame changes to the divider, the timing fields and the enable are applied at random moments. A design that applied them at once would shift the positions and the sync edges in the middle of a frame. A design that ignored a cleared enable would never go idle. A clear strobe given in the same cycle as a frame start checks that the set takes priority; getting it wrong loses the interrupt for that frame.

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing #(
  parameter int PW = 8,
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] hsw_m1,
  input  logic [PW-1:0] hbp_m1,
  input  logic [PW-1:0] hfp_m1,
  input  logic [AW-1:0] hact_m1,
  input  logic [PW-1:0] vsw_m1,
  input  logic [PW-1:0] vbp_m1,
  input  logic [PW-1:0] vfp_m1,
  input  logic [AW-1:0] vact_m1,
  input  logic          inv_hsync,
  input  logic          inv_vsync,
  input  logic          inv_de,
  input  logic          inv_pclk,
  input  logic [DW-1:0] div_m1,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk,
  output logic [AW+1:0] h_pos,
  output logic [AW+1:0] v_pos,
  output logic          irq
);
  localparam int CW = AW + 2;

  logic          run;
  logic [DW-1:0] ratio, dcnt;
  logic [CW-1:0] h, v;
  logic [CW-1:0] s_hs, s_ha, s_hf, s_hl, s_vs, s_va, s_vf, s_vl;

  wire [CW-1:0] c_hs = CW'(hsw_m1) + CW'(1);
  wire [CW-1:0] c_ha = c_hs + CW'(hbp_m1) + CW'(1);
  wire [CW-1:0] c_hf = c_ha + CW'(hact_m1) + CW'(1);
  wire [CW-1:0] c_hl = c_hf + CW'(hfp_m1);
  wire [CW-1:0] c_vs = CW'(vsw_m1) + CW'(1);
  wire [CW-1:0] c_va = c_vs + CW'(vbp_m1) + CW'(1);
  wire [CW-1:0] c_vf = c_va + CW'(vact_m1) + CW'(1);
  wire [CW-1:0] c_vl = c_vf + CW'(vfp_m1);
  wire [DW-1:0] c_ratio = (div_m1 == '1) ? div_m1 : div_m1 + DW'(1);

  wire tick  = run && (dcnt == ratio - DW'(1));
  wire h_end = (h == s_hl);
  wire v_end = (v == s_vl);
  wire wrap  = tick && h_end && v_end;
  wire load  = (!run || wrap) && enable;
  wire stop  = wrap && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; ratio <= DW'(1); dcnt <= '0; h <= '0; v <= '0;
      s_hs <= '0; s_ha <= '0; s_hf <= '0; s_hl <= '0;
      s_vs <= '0; s_va <= '0; s_vf <= '0; s_vl <= '0;
    end else if (load) begin
      run <= 1'b1; ratio <= c_ratio; dcnt <= '0; h <= '0; v <= '0;
      s_hs <= c_hs; s_ha <= c_ha; s_hf <= c_hf; s_hl <= c_hl;
      s_vs <= c_vs; s_va <= c_va; s_vf <= c_vf; s_vl <= c_vl;
    end else if (stop) begin
      run <= 1'b0; dcnt <= '0; h <= '0; v <= '0;
    end else if (tick) begin
      dcnt <= '0;
      h <= h_end ? '0 : h + CW'(1);
      if (h_end) v <= v_end ? '0 : v + CW'(1);
    end else if (run) begin
      dcnt <= dcnt + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             irq <= 1'b0;
    else if (load && irq_en) irq <= 1'b1;
    else if (irq_clr)       irq <= 1'b0;
  end

  wire hs_act = run && (h < s_hs);
  wire vs_act = run && (v < s_vs);
  wire de_act = run && (h >= s_ha) && (h < s_hf) && (v >= s_va) && (v < s_vf);
  wire pc_raw = run && ((ratio == DW'(1)) ? clk : (dcnt >= (ratio >> 1)));

  assign hsync = ~hs_act ^ inv_hsync;
  assign vsync = ~vs_act ^ inv_vsync;
  assign de    = de_act ^ inv_de;
  assign pclk  = pc_raw ^ inv_pclk;
  assign h_pos = h;
  assign v_pos = v;
endmodule

module rgb_panel_timing_chk #(
  parameter int DW = 8,
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          load,
  input logic          irq_clr,
  input logic          irq,
  input logic [DW-1:0] ratio,
  input logic [CW-1:0] h_pos,
  input logic [CW-1:0] v_pos,
  input logic [CW-1:0] s_hl,
  input logic          hs_act,
  input logic          vs_act,
  input logic          de_act
);
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr && !load |=> !irq);
  // R10
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ratio));
  // R4
  de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> !hs_act && !vs_act);
  // R8
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> h_pos <= s_hl);
  // R11
  idle_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> h_pos == '0 && v_pos == '0);
endmodule

bind rgb_panel_timing rgb_panel_timing_chk #(.DW(DW), .CW(AW + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .load(load), .irq_clr(irq_clr),
  .irq(irq), .ratio(ratio), .h_pos(h_pos), .v_pos(v_pos), .s_hl(s_hl),
  .hs_act(hs_act), .vs_act(vs_act), .de_act(de_act)
);

// File: tb/test_rgb_panel_timing.sv
module test_rgb_panel_timing;
  localparam int PW = 8, AW = 12, DW = 8, CW = AW + 2;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [PW-1:0] hsw_m1 = '0, hbp_m1 = '0, hfp_m1 = '0, vsw_m1 = '0, vbp_m1 = '0, vfp_m1 = '0;
  logic [AW-1:0] hact_m1 = '0, vact_m1 = '0;
  logic inv_hsync = 0, inv_vsync = 0, inv_de = 0, inv_pclk = 0, irq_en = 0, irq_clr = 0;
  logic [DW-1:0] div_m1 = '0;
  logic hsync, vsync, de, pclk, irq;
  logic [CW-1:0] h_pos, v_pos;

  int vectors = 0, fails = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #2.5 clk = ~clk;

  rgb_panel_timing #(.PW(PW), .AW(AW), .DW(DW)) i_rgb_panel_timing (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hsw_m1(hsw_m1), .hbp_m1(hbp_m1), .hfp_m1(hfp_m1), .hact_m1(hact_m1),
    .vsw_m1(vsw_m1), .vbp_m1(vbp_m1), .vfp_m1(vfp_m1), .vact_m1(vact_m1),
    .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de), .inv_pclk(inv_pclk),
    .div_m1(div_m1), .irq_en(irq_en), .irq_clr(irq_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk),
    .h_pos(h_pos), .v_pos(v_pos), .irq(irq)
  );

  // reference state
  bit m_run, m_irq;
  int m_h, m_v, m_d, m_ratio = 1;
  int m_hs, m_ha, m_hf, m_hl, m_vs, m_va, m_vf, m_vl;

  always @(posedge clk) begin
    bit tk, wr, ld;
    if (!rst_n) begin
      m_run = 0; m_irq = 0; m_h = 0; m_v = 0; m_d = 0; m_ratio = 1;
    end else begin
      tk = m_run && (m_d == m_ratio - 1);
      wr = tk && (m_h == m_hl) && (m_v == m_vl);
      ld = (!m_run || wr) && enable;
      if (ld && irq_en) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (ld) begin
        m_run = 1; m_h = 0; m_v = 0; m_d = 0;
        m_ratio = (div_m1 == 8'd255) ? 255 : int'(div_m1) + 1;
        m_hs = hsw_m1 + 1; m_ha = m_hs + hbp_m1 + 1; m_hf = m_ha + hact_m1 + 1; m_hl = m_hf + hfp_m1;
        m_vs = vsw_m1 + 1; m_va = m_vs + vbp_m1 + 1; m_vf = m_va + vact_m1 + 1; m_vl = m_vf + vfp_m1;
      end else if (wr) begin
        m_run = 0; m_h = 0; m_v = 0; m_d = 0;
      end else if (tk) begin
        m_d = 0;
        if (m_h == m_hl) begin
          m_h = 0;
          m_v = (m_v == m_vl) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end else if (m_run) m_d = m_d + 1;
    end
  end

  function automatic bit exp_hs(); return !(m_run && m_h < m_hs) ^ inv_hsync; endfunction
  function automatic bit exp_vs(); return !(m_run && m_v < m_vs) ^ inv_vsync; endfunction
  function automatic bit exp_de();
    return (m_run && m_h >= m_ha && m_h < m_hf && m_v >= m_va && m_v < m_vf) ^ inv_de;
  endfunction
  function automatic bit exp_pc();
    bit raw = m_run && ((m_ratio == 1) ? clk : (m_d >= m_ratio / 2));
    return raw ^ inv_pclk;
  endfunction

  task automatic chk(string req, string sig, int got, int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s got %0d exp %0d", req, phase, sig, got, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("R2", "hsync", hsync, exp_hs());
      chk("R3", "vsync", vsync, exp_vs());
      chk("R4", "de", de, exp_de());
      chk("R6", "pclk", pclk, exp_pc());
      chk("R8", "h_pos", h_pos, m_h);
      chk("R8", "v_pos", v_pos, m_v);
      chk("R9", "irq", irq, m_irq);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rand_cfg();
    hsw_m1 = PW'($urandom_range(0, 3)); hbp_m1 = PW'($urandom_range(0, 3));
    hact_m1 = AW'($urandom_range(0, 7)); hfp_m1 = PW'($urandom_range(0, 3));
    vsw_m1 = PW'($urandom_range(0, 2)); vbp_m1 = PW'($urandom_range(0, 2));
    vact_m1 = AW'($urandom_range(0, 5)); vfp_m1 = PW'($urandom_range(0, 2));
    div_m1 = DW'($urandom_range(0, 4));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    void'($urandom(32'd2024));
    wait_cyc(4);
    @(negedge clk); rst_n = 1;
    wait_cyc(4);
    phase = "R12 start";
    hsw_m1 = 1; hbp_m1 = 2; hact_m1 = 5; hfp_m1 = 1;
    vsw_m1 = 0; vbp_m1 = 1; vact_m1 = 3; vfp_m1 = 0;
    div_m1 = 0; irq_en = 1; enable = 1;
    phase = "R7 bypass";
    wait_cyc(220);
    phase = "R9 clear";
    irq_clr = 1; wait_cyc(1); irq_clr = 0;
    wait_cyc(30);
    phase = "R10 mid-frame change";
    div_m1 = 2; hact_m1 = 2;
    wait_cyc(400);
    phase = "R5 inversion";
    for (int k = 0; k < 16; k++) begin
      {inv_hsync, inv_vsync, inv_de, inv_pclk} = 4'(k);
      wait_cyc(13);
    end
    phase = "R2 min fields";
    hsw_m1 = 0; hbp_m1 = 0; hact_m1 = 0; hfp_m1 = 0;
    vsw_m1 = 0; vbp_m1 = 0; vact_m1 = 0; vfp_m1 = 0; div_m1 = 1;
    wait_cyc(200);
    phase = "R6 saturation";
    div_m1 = 8'd255;
    wait_cyc(9000);
    phase = "R3 random";
    for (int s = 0; s < 18; s++) begin
      rand_cfg();
      {inv_hsync, inv_vsync, inv_de, inv_pclk} = 4'($urandom);
      irq_en = 1'($urandom);
      wait_cyc($urandom_range(100, 700));
      irq_clr = 1'($urandom); wait_cyc(1); irq_clr = 0;
    end
    phase = "R11 stop";
    enable = 0;
    wait_cyc(1600);
    {inv_hsync, inv_vsync, inv_de, inv_pclk} = 4'b1010;
    wait_cyc(5);
    {inv_hsync, inv_vsync, inv_de, inv_pclk} = 4'b0000;
    phase = "R1 idle levels";
    wait_cyc(5);
    phase = "R12 restart";
    irq_en = 1; irq_clr = 1; enable = 1;
    wait_cyc(1);
    irq_clr = 0;
    wait_cyc(300);
    done = 1;
    report();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog [%s] got timeout exp completion", phase);
      report();
      $finish;
    end
  end
endmodule